// File: doc/BRIEF.md
# SMBus Register-Access Slave with Bus Timeout

This block is the serial front end of a small register file on a two-wire SMBus. It watches SCL and SDA and pulls SDA low through an open-drain enable. It recognises one fixed 7-bit device address and turns bus traffic into a plain register-file access made of a pointer, write data, a write strobe and read data. It handles four transactions. A pointer-only write sets the pointer. A pointer-plus-data write stores a byte. A bare read returns the register at the stored pointer. A combined transaction sets the pointer and then, after a repeated start, reads.

The pointer is kept between transactions, so a read can be addressed on its own. While the chip's alert input is asserted, the slave also answers the alert response address and returns its own address. It then pulses an alert-done output so that the requester can drop the alert. A counter that runs while SCL is low abandons a stuck transaction: it releases SDA and waits for the next start condition.

Top module: `smb_regport_slave`

## Requirements
- R1: A byte whose upper seven bits equal the device address 0x4C is acknowledged with either R/W value (0x98 write, 0x99 read). Any other address byte is not acknowledged, and the slave drives nothing until the next start condition.
- R2: An address byte with R/W=0, followed by one byte and a stop, loads that byte into the pointer (reg_addr) and raises no write strobe.
- R3: An address byte with R/W=0, a pointer byte and a data byte, each acknowledged, produces exactly one single-cycle reg_we with reg_addr equal to the new pointer and reg_wdata equal to the data byte. A fourth byte is not acknowledged and causes no write.
- R4: A read (address byte with R/W=1) that follows a start directly shifts out the register at the stored pointer, MSB first.
- R5: A pointer byte followed by a repeated start and a read returns the register at the pointer just written.
- R6: The alert response address byte 0x19 (address 0x0C, R/W=1) is acknowledged only while alert_req is high. The data byte returned is the device address in bits 7:1 with bit 0 clear (0x98). alert_done pulses for one cycle after that byte has been sent. With alert_req low, the byte is not acknowledged.
- R7: If SCL stays low for the timeout window (CLK_KHZ*TIMEOUT_US/1000 cycles), the slave releases SDA and returns to idle. Later bytes are ignored until a new start.
- R8: A start condition at any bit position restarts reception of an address byte from bit 7.
- R9: sda_oe changes only while SCL is low. It is released after each ACK bit and after the last data bit of a read, and it is never asserted during bits the master drives.
- R10: After reset sda_oe, reg_we and alert_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL as seen on the pad (asynchronous) |
| sda_in | input | 1 | SDA as seen on the pad (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| alert_req | input | 1 | Alert pending; enables the alert response answer |
| alert_done | output | 1 | One-cycle pulse once the alert response byte was sent |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register read data at reg_addr |

## Verification
The bench goes after the places where bus framing is easy to get wrong. A pointer-only write must not also strobe a write: a design that counted bytes carelessly would corrupt the register at the old pointer. A repeated start must not lose the freshly loaded pointer, and a start in the middle of a byte must realign the bit counter; a misaligned design acknowledges the wrong address or returns shifted data. The bench also holds SCL low while the slave drives ACK and confirms that SDA is freed and the rest of that transaction is ignored. It reads the alert response address with and without a pending alert, because answering without a pending alert would collide with other devices on the bus.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam logic [6:0] DEV_ADDR_DEF = 7'h4C;
    localparam logic [6:0] ALERT_RESP_ADDR = 7'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TX_END
    } smb_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
        return b[7:1] == a;
    endfunction

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync
    import smb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_pin,
    input  logic    sda_pin,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q;
    logic scl_now, sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
            sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_now = scl_ff[STAGES-1];
    assign sda_now = sda_ff[STAGES-1];

    always_comb begin
        ev.scl   = scl_now;
        ev.sda   = sda_now;
        ev.start = scl_now & scl_q & sda_q & ~sda_now;
        ev.stop  = scl_now & scl_q & ~sda_q & sda_now;
        ev.rise  = scl_now & ~scl_q;
        ev.fall  = ~scl_now & scl_q;
    end

endmodule

// File: rtl/smb_scl_timeout.sv
module smb_scl_timeout #(
    parameter int unsigned LIMIT = 3000000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (scl) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            if (cnt != TOP) cnt <= cnt + 1'b1;
            expired <= (cnt == LAST);
        end
    end

    AST_TMO_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        expired |-> !$past(scl)); // R7

endmodule

// File: rtl/smb_regport_slave.sv
module smb_regport_slave
    import smb_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 100000,
    parameter int unsigned TIMEOUT_US = 30000,
    parameter logic [6:0]  DEV_ADDR   = DEV_ADDR_DEF,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       alert_req,
    output logic       alert_done,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam int unsigned TMO_CYCLES = CLK_KHZ * TIMEOUT_US / 1000;

    bus_ev_t    ev;
    logic       tmo;
    smb_state_e state, after_ack;
    logic [2:0] bit_cnt;
    logic [6:0] sh;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic [1:0] byte_idx;
    logic       ack_on;
    logic       from_ara;
    logic [7:0] b_in;

    smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_pin(scl_in), .sda_pin(sda_in), .ev(ev)
    );

    smb_scl_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst(rst), .scl(ev.scl), .expired(tmo)
    );

    assign b_in     = {sh, ev.sda};
    assign reg_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            bit_cnt    <= '0;
            sh         <= '0;
            tx         <= '0;
            ptr        <= '0;
            byte_idx   <= '0;
            ack_on     <= 1'b0;
            from_ara   <= 1'b0;
            sda_oe     <= 1'b0;
            reg_we     <= 1'b0;
            reg_wdata  <= '0;
            alert_done <= 1'b0;
        end else begin
            reg_we     <= 1'b0;
            alert_done <= 1'b0;
            if (tmo) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (ev.rise) begin
                        sh      <= b_in[6:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) begin
                            ack_on <= 1'b0;
                            if (addr_hit(b_in, DEV_ADDR)) begin
                                state    <= ST_ACK;
                                from_ara <= 1'b0;
                                if (b_in[0]) begin
                                    after_ack <= ST_TX;
                                    tx        <= reg_rdata;
                                end else begin
                                    after_ack <= ST_RX;
                                    byte_idx  <= '0;
                                end
                            end else if (addr_hit(b_in, ALERT_RESP_ADDR) && b_in[0] && alert_req) begin
                                state     <= ST_ACK;
                                after_ack <= ST_TX;
                                tx        <= {DEV_ADDR, 1'b0};
                                from_ara  <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_RX: if (ev.rise) begin
                        sh      <= b_in[6:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) begin
                            ack_on    <= 1'b0;
                            after_ack <= ST_RX;
                            if (byte_idx == 2'd0) begin
                                ptr      <= b_in;
                                byte_idx <= 2'd1;
                                state    <= ST_ACK;
                            end else if (byte_idx == 2'd1) begin
                                reg_wdata <= b_in;
                                reg_we    <= 1'b1;
                                byte_idx  <= 2'd2;
                                state     <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: if (ev.fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1;
                            ack_on <= 1'b1;
                        end else begin
                            ack_on  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= after_ack;
                            if (after_ack == ST_TX) begin
                                sda_oe <= ~tx[7];
                                tx     <= {tx[6:0], 1'b0};
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) state <= ST_TX_END;
                        end else if (ev.fall) begin
                            sda_oe <= ~tx[7];
                            tx     <= {tx[6:0], 1'b0};
                        end
                    end
                    ST_TX_END: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            if (from_ara) begin
                                alert_done <= 1'b1;
                                from_ara   <= 1'b0;
                            end
                        end else if (ev.rise) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(ev.scl)); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we); // R3
    AST_WE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> ev.scl); // R3
    AST_TMO_FREES_SDA: assert property (@(posedge clk) disable iff (rst)
        tmo |=> !sda_oe); // R7
    AST_ALERT_PULSE: assert property (@(posedge clk) disable iff (rst)
        alert_done |=> !alert_done); // R6
    AST_START_FREES_SDA: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe); // R8

endmodule

// File: tb/tb_smb_regport_slave.sv
`timescale 1ns/1ps
module tb_smb_regport_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, alert_req, alert_done, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_bus;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int compared = 0;
    int mismatched = 0;
    int we_cnt = 0;
    int alert_cnt = 0;
    logic seen_bus, seen_oe;
    bit finished = 0;

    always #5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_regport_slave #(.CLK_KHZ(100000), .TIMEOUT_US(20)) dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .alert_req(alert_req), .alert_done(alert_done),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (alert_done) alert_cnt <= alert_cnt + 1;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic drive);
        scl = 1'b0; w(Q);
        sda_m = drive; w(Q);
        scl = 1'b1; w(Q);
        seen_bus = sda_bus; seen_oe = sda_oe; w(Q);
    endtask

    task automatic bus_start();
        scl = 1'b0; w(Q);
        sda_m = 1'b1; w(Q);
        scl = 1'b1; w(2*Q);
        sda_m = 1'b0; w(2*Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; w(Q);
        sda_m = 1'b0; w(Q);
        scl = 1'b1; w(2*Q);
        sda_m = 1'b1; w(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input string rq);
        for (int i = 7; i > 7 - n; i--) begin
            bit_cycle(b[i]);
            check({rq, " R9 quiet on master bit"}, seen_oe, 0);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, input string rq);
        send_bits(b, 8, rq);
        bit_cycle(1'b1);
        check({rq, " ack bit"}, seen_bus, ack ? 0 : 1);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input string rq);
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1);
            check({rq, " data bit"}, seen_bus, exp[i]);
        end
        bit_cycle(1'b1);
        check({rq, " R9 released on master NACK"}, seen_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        alert_req = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        w(5);
        check("R10 sda_oe in reset", sda_oe, 0);
        check("R10 reg_we in reset", reg_we, 0);
        check("R10 alert_done in reset", alert_done, 0);
        rst = 1'b0; w(10);
        check("R10 sda_oe after reset", sda_oe, 0);

        // R3: full write to 0x15
        bus_start();
        send_byte(8'h98, 1, "R1 write addr");
        send_byte(8'h15, 1, "R3 pointer");
        send_byte(8'hA7, 1, "R3 data");
        bus_stop();
        exp_mem[8'h15] = 8'hA7;
        check("R3 write count", we_cnt, 1);
        check("R3 stored", mem[8'h15], exp_mem[8'h15]);

        // R2: pointer only
        bus_start();
        send_byte(8'h98, 1, "R2 addr");
        send_byte(8'h40, 1, "R2 pointer");
        bus_stop();
        check("R2 no write strobe", we_cnt, 1);
        check("R2 pointer loaded", reg_addr, 8'h40);

        // R4: bare read at stored pointer
        bus_start();
        send_byte(8'h99, 1, "R1 read addr");
        recv_byte(exp_mem[8'h40], "R4 read");
        bus_stop();

        // R5: combined read of 0x15
        bus_start();
        send_byte(8'h98, 1, "R5 addr");
        send_byte(8'h15, 1, "R5 pointer");
        bus_start();
        send_byte(8'h99, 1, "R5 read addr");
        recv_byte(exp_mem[8'h15], "R5 read");
        bus_stop();
        check("R5 no write", we_cnt, 1);

        // R3: extra byte after data is refused
        bus_start();
        send_byte(8'h98, 1, "R3 addr");
        send_byte(8'h22, 1, "R3 pointer");
        send_byte(8'h5C, 1, "R3 data");
        send_byte(8'h33, 0, "R3 extra byte");
        bus_stop();
        exp_mem[8'h22] = 8'h5C;
        check("R3 single write", we_cnt, 2);
        check("R3 stored 22", mem[8'h22], exp_mem[8'h22]);

        // R1: foreign address ignored
        bus_start();
        send_byte(8'h90, 0, "R1 foreign addr");
        send_byte(8'h01, 0, "R1 ignored byte");
        send_byte(8'hFF, 0, "R1 ignored byte2");
        bus_stop();
        check("R1 no write on foreign", we_cnt, 2);

        // R6: alert response without request
        bus_start();
        send_byte(8'h19, 0, "R6 no alert");
        bus_stop();
        check("R6 no pulse", alert_cnt, 0);
        alert_req = 1'b1;
        bus_start();
        send_byte(8'h19, 1, "R6 alert addr");
        recv_byte(8'h98, "R6 own address");
        bus_stop();
        check("R6 one pulse", alert_cnt, 1);
        alert_req = 1'b0;

        // R8: start in the middle of a byte
        bus_start();
        send_bits(8'hA0, 4, "R8 partial");
        bus_start();
        send_byte(8'h98, 1, "R8 addr after restart");
        send_byte(8'h30, 1, "R8 pointer");
        bus_stop();
        bus_start();
        send_byte(8'h99, 1, "R8 read addr");
        recv_byte(exp_mem[8'h30], "R8 read");
        bus_stop();

        // R7: SCL held low during ACK
        bus_start();
        send_bits(8'h98, 8, "R7 addr");
        scl = 1'b0; w(2*Q);
        check("R7 ack driven before timeout", sda_oe, 1);
        w(2500);
        check("R7 released after timeout", sda_oe, 0);
        sda_m = 1'b1; w(Q);
        scl = 1'b1; w(2*Q);
        send_byte(8'h50, 0, "R7 ignored after timeout");
        send_byte(8'h66, 0, "R7 ignored data");
        bus_stop();
        check("R7 no write", we_cnt, 2);
        check("R7 pointer kept", reg_addr, 8'h30);

        bus_start();
        send_byte(8'h99, 1, "R7 recovered read addr");
        recv_byte(exp_mem[8'h30], "R7 recovered read");
        bus_stop();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule